// File: doc/BRIEF.md
# Ordered Dial Code Lock

This block is a clocked state machine for a dial lock that opens only when a three-step code is entered in the correct order. Each entry has three parts: a direction bit, a dial value, and a one-cycle enter strobe. The default code is right to 13, then left to 22, then right to 3. The code values and directions are fixed parameters. They cannot be changed while the block runs.

The machine has four states: idle, first step accepted, two steps accepted, and open. The open output is driven only in the open state. Once the lock is open it stays open and ignores further entries until the relock pulse is given. A wrong entry makes the machine start over. If that wrong entry happens to be the first step of the code, it is taken as a fresh start.

Top module: `combo_lock`

## Requirements
- R1: A synchronous reset, with `rst_n` low at a rising clock edge, puts the machine in the idle state with `is_open` low. This holds even when the reset arrives part-way through a code.
- R2: The steps must be entered as R-13, then L-22, then R-3, where R means `dir_right`=1 and L means `dir_right`=0. After the edge that captures the third correct step, `is_open` goes high. It is low after only one or two correct steps.
- R3: Dial and direction values are ignored on any cycle where `enter` is low. Idle cycles between correct steps do not break the sequence.
- R4: In the idle state, the first-step state or the two-step state, a wrong entry returns the machine to idle. Entering the remaining steps after that does not open the lock.
- R5: If a wrong entry is R-13 (the first step), the machine goes to the first-step state instead of idle. In particular, R-13 given while waiting for L-22 or for R-3 keeps the first step.
- R6: While open, the machine stays open with `is_open` high, and every entry is ignored, until relock is given.
- R7: When `relock` is high at an edge, the machine goes to idle from any state. If `enter` is high in the same cycle, relock takes priority.
- R8: The direction is part of each step. The right value entered with the wrong direction counts as a wrong entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enter | input | 1 | One-cycle strobe that submits the current dial entry |
| dir_right | input | 1 | Turn direction of the entry: 1 right, 0 left |
| dial | input | 6 | Unsigned dial position of the entry |
| relock | input | 1 | Returns the lock to idle; has priority over enter |
| is_open | output | 1 | High only while the machine is in the open state |

## Verification
Two functions can fall in the same cycle: a relock and an enter strobe. The bench provokes this by sending the final correct step with `relock` held high in that same cycle. The lock must stay closed. After that, the last two steps alone must not open it, which shows the machine is in idle and not in the two-step state. A cycle-by-cycle reference model also compares `is_open` on every clock during all the other sequences. These include wrong entries, restarts on R-13, wrong directions, gaps between steps, and a reset given mid-code.

// File: rtl/lock_pkg.sv
// Shared types for the ordered dial code lock.
// Assumes a three-step code, so four states fit in two bits.
package lock_pkg;
    localparam int STEPS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_t;
endpackage

// File: rtl/lock_step_match.sv
// Compares one dial entry against every step of the fixed code at once.
// Assumes the code values and directions are elaboration-time constants.
module lock_step_match
    import lock_pkg::*;
#(
    parameter int unsigned       DIAL_W      = 6,
    parameter logic [DIAL_W-1:0] STEP0_VAL   = 6'd13,
    parameter bit                STEP0_RIGHT = 1'b1,
    parameter logic [DIAL_W-1:0] STEP1_VAL   = 6'd22,
    parameter bit                STEP1_RIGHT = 1'b0,
    parameter logic [DIAL_W-1:0] STEP2_VAL   = 6'd3,
    parameter bit                STEP2_RIGHT = 1'b1
) (
    input  logic              dir_right,
    input  logic [DIAL_W-1:0] dial,
    output logic [STEPS-1:0]  hit
);
    localparam logic [DIAL_W-1:0] VALS [STEPS] = '{STEP0_VAL, STEP1_VAL, STEP2_VAL};
    localparam bit                DIRS [STEPS] = '{STEP0_RIGHT, STEP1_RIGHT, STEP2_RIGHT};

    // One comparator per code step: the value and the direction must both agree.
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign hit[g] = (dial == VALS[g]) && (dir_right == DIRS[g]);
    end
endmodule

// File: rtl/lock_next_state.sv
// Next-state logic of the lock.
// Relock has priority over enter. A wrong entry restarts the code, or keeps
// the first step if the entry equals it. The open state ignores entries.
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_t      cur,
    input  logic             enter,
    input  logic             relock,
    input  logic [STEPS-1:0] hit,
    output lock_state_t      nxt
);
    lock_state_t restart;

    // Where a wrong entry leads: to the first-step state if it matches step 0.
    assign restart = hit[0] ? ST_ONE : ST_IDLE;

    // Picks the state for the next edge.
    always_comb begin
        nxt = cur;
        if (relock) begin
            nxt = ST_IDLE;
        end else if (enter) begin
            unique case (cur)
                ST_IDLE: nxt = hit[0] ? ST_ONE  : ST_IDLE;
                ST_ONE:  nxt = hit[1] ? ST_TWO  : restart;
                ST_TWO:  nxt = hit[2] ? ST_OPEN : restart;
                ST_OPEN: nxt = ST_OPEN;
                default: nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/combo_lock.sv
// Top of the ordered dial code lock: the state register, the step matcher
// and the next-state logic. The open output is decoded from the state alone.
// Assumes inputs are synchronous to clk; the reset is synchronous and active low.
module combo_lock
    import lock_pkg::*;
#(
    parameter int unsigned       DIAL_W      = 6,
    parameter logic [DIAL_W-1:0] STEP0_VAL   = 6'd13,
    parameter bit                STEP0_RIGHT = 1'b1,
    parameter logic [DIAL_W-1:0] STEP1_VAL   = 6'd22,
    parameter bit                STEP1_RIGHT = 1'b0,
    parameter logic [DIAL_W-1:0] STEP2_VAL   = 6'd3,
    parameter bit                STEP2_RIGHT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic              dir_right,
    input  logic [DIAL_W-1:0] dial,
    input  logic              relock,
    output logic              is_open
);
    lock_state_t      state;
    lock_state_t      state_nxt;
    logic [STEPS-1:0] hit;

    lock_step_match #(
        .DIAL_W(DIAL_W),
        .STEP0_VAL(STEP0_VAL), .STEP0_RIGHT(STEP0_RIGHT),
        .STEP1_VAL(STEP1_VAL), .STEP1_RIGHT(STEP1_RIGHT),
        .STEP2_VAL(STEP2_VAL), .STEP2_RIGHT(STEP2_RIGHT)
    ) u_match (
        .dir_right(dir_right),
        .dial(dial),
        .hit(hit)
    );

    lock_next_state u_next (
        .cur(state),
        .enter(enter),
        .relock(relock),
        .hit(hit),
        .nxt(state_nxt)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Open decode: high in the open state only.
    assign is_open = (state == ST_OPEN);

    // R1: a reset edge leaves the machine idle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (state == ST_IDLE));

    // R3: without enter or relock the state holds.
    a_r3_hold_without_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter && !relock) |=> $stable(state));

    // R2: the lock opens only right after an accepted entry.
    a_r2_open_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(enter && !relock));

    // R6: open stays open unless relock is given.
    a_r6_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !relock) |=> is_open);

    // R7: relock always closes, whatever enter does.
    a_r7_relock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> (state == ST_IDLE));

    // R5: an entry of the first step never leads to idle.
    a_r5_first_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !relock && hit[0] && state != ST_OPEN) |=> (state != ST_IDLE));
endmodule

// File: tb/test_combo_lock.sv
// Self-checking bench for combo_lock.
// A behavioural reference model is compared with is_open on every clock,
// and named checks are made at the points where each test scenario ends.
module test_combo_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter = 1'b0;
    logic       dir_right = 1'b0;
    logic [5:0] dial = '0;
    logic       relock = 1'b0;
    logic       is_open;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    progress = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    combo_lock i_combo_lock (
        .clk(clk), .rst_n(rst_n), .enter(enter), .dir_right(dir_right),
        .dial(dial), .relock(relock), .is_open(is_open)
    );

    always #2 clk = ~clk;

    // Reference model: progress counts accepted steps; 3 means open.
    always @(posedge clk) begin
        int want_val [3];
        bit want_dir [3];
        want_val = '{13, 22, 3};
        want_dir = '{1'b1, 1'b0, 1'b1};
        if (!rst_n || relock) progress <= 0;
        else if (enter && progress != 3) begin
            if (dial == want_val[progress] && dir_right == want_dir[progress])
                progress <= progress + 1;
            else if (dial == 13 && dir_right)
                progress <= 1;
            else
                progress <= 0;
        end
    end

    // Compares the design with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            n_checks++;
            if (is_open !== (progress == 3)) begin
                n_fail++;
                $display("FAIL %s model compare: is_open=%b expected %b at %0t",
                         cur_req, is_open, (progress == 3), $time);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check_open(input bit exp, input string req);
        n_checks++;
        if (is_open !== exp) begin
            n_fail++;
            $display("FAIL %s: is_open=%b expected %b at %0t", req, is_open, exp, $time);
        end
    endtask

    task automatic step(input bit right, input int val);
        @(negedge clk);
        enter = 1'b1; dir_right = right; dial = 6'(val);
        @(negedge clk);
        enter = 1'b0;
    endtask

    task automatic do_relock();
        @(negedge clk);
        relock = 1'b1;
        @(negedge clk);
        relock = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        check_open(1'b0, "R1");
        rst_n = 1'b1;
        idle(1);

        // R2: the code in order opens the lock.
        cur_req = "R2";
        step(1, 13); check_open(1'b0, "R2");
        step(0, 22); check_open(1'b0, "R2");
        step(1, 3);  check_open(1'b1, "R2");

        // R6: entries are ignored while open.
        cur_req = "R6";
        step(0, 5);  step(1, 13); step(1, 63);
        idle(3);
        check_open(1'b1, "R6");

        // R7: relock closes the lock.
        cur_req = "R7";
        do_relock(); check_open(1'b0, "R7");

        // R3: values without enter are ignored; gaps keep the sequence.
        cur_req = "R3";
        @(negedge clk); dir_right = 1'b1; dial = 6'd13;
        @(negedge clk); dir_right = 1'b0; dial = 6'd22;
        @(negedge clk); dir_right = 1'b1; dial = 6'd3;
        idle(2);
        check_open(1'b0, "R3");
        step(1, 13); idle(4);
        step(0, 22); idle(5);
        step(1, 3);
        check_open(1'b1, "R3");
        do_relock();

        // R4: a wrong entry restarts the code.
        cur_req = "R4";
        step(1, 13); step(0, 5); step(0, 22); step(1, 3);
        check_open(1'b0, "R4");
        step(1, 13); step(0, 22); step(1, 4); step(1, 3);
        check_open(1'b0, "R4");
        step(1, 3); step(0, 22); step(1, 13);
        check_open(1'b0, "R4");
        step(0, 22); step(1, 3);
        check_open(1'b1, "R4");
        do_relock();

        // R5: a wrong entry equal to the first step keeps step one.
        cur_req = "R5";
        step(1, 13); step(0, 22); step(1, 13);
        check_open(1'b0, "R5");
        step(0, 22); step(1, 3);
        check_open(1'b1, "R5");
        do_relock();
        step(1, 13); step(1, 13); step(0, 22); step(1, 3);
        check_open(1'b1, "R5");
        do_relock();

        // R8: the right value with the wrong direction does not count.
        cur_req = "R8";
        step(0, 13); step(0, 22); step(1, 3);
        check_open(1'b0, "R8");
        step(1, 13); step(1, 22); step(1, 3);
        check_open(1'b0, "R8");
        step(1, 13); step(0, 22); step(0, 3);
        check_open(1'b0, "R8");

        // R7: relock and enter in the same cycle; relock must win.
        cur_req = "R7";
        step(1, 13); step(0, 22);
        @(negedge clk);
        enter = 1'b1; relock = 1'b1; dir_right = 1'b1; dial = 6'd3;
        @(negedge clk);
        enter = 1'b0; relock = 1'b0;
        check_open(1'b0, "R7");
        step(0, 22); step(1, 3);
        check_open(1'b0, "R7");
        step(1, 13); do_relock(); step(0, 22); step(1, 3);
        check_open(1'b0, "R7");

        // R1: reset in the middle of a code.
        cur_req = "R1";
        step(1, 13); step(0, 22);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_open(1'b0, "R1");
        step(1, 3);
        check_open(1'b0, "R1");

        idle(2);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule